// File: doc/BRIEF.md
# Resettable Pseudorandom Bit Generator

This block supplies one random bit to the condition-test logic of a processor core. The heads and tails tests read that bit. The bit comes from a ten-stage linear feedback shift register that steps once for each heads or tails test the core evaluates. On every other cycle it holds its value.

The block also watches writes to the register that holds the interrupt-return address. If such a write happens while the core is outside an interrupt service routine, and the mode bit that blocks reseeding is clear, the register reloads its fixed seed. Inside a service routine, or while the blocking mode bit is set, the write leaves the sequence alone. Storage of the address register and interrupt handling belong to other blocks.

Top module: `prbit_gen`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, the state equals the seed 10'h001, so `rand_bit` (state bit 9) reads 0.
- R2: When `step_en` is high and no reseed happens, the state shifts toward bit 9 in one cycle. The new bit 0 is state[9] XOR state[6], which is the polynomial x^10 + x^7 + 1.
- R3: When `step_en` is low and no reseed happens, the state and `rand_bit` stay unchanged.
- R4: A high `ret_wr` with `in_isr` low and `no_reseed` low reloads the seed 10'h001 on the next edge.
- R5: A high `ret_wr` with `in_isr` high has no effect on the sequence. It steps only if `step_en` is high, and otherwise holds.
- R6: A high `ret_wr` with `no_reseed` high never reloads the seed, whatever the value of `in_isr`.
- R7: When a reseeding write and `step_en` fall in the same cycle, the reseed wins and the state becomes 10'h001.
- R8: Starting from the seed, 1023 steps bring the state back to the seed, and no earlier step does. Over that period `rand_bit` is 1 in 512 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | A heads or tails test is evaluated this cycle |
| ret_wr | input | 1 | Write strobe for the interrupt-return address register |
| in_isr | input | 1 | Core is inside an interrupt service routine |
| no_reseed | input | 1 | Mode bit: when set, writes never reseed |
| rand_bit | output | 1 | Current random bit (last stage) |

## Verification
Two actions can land in the same cycle: a step request and a write to the return-address register. The bench drives both strobes together and sweeps `in_isr` and `no_reseed` through all four combinations. A reference model written as an integer recurrence predicts the bit on every clock. If the write is allowed to reseed, the model expects the seed regardless of the step request. If the write is gated off, the model expects a plain step. A long run of steps checks the period and the count of ones.

// File: rtl/prbit_pkg.sv
package prbit_pkg;
  localparam int unsigned STAGES = 10;
  localparam int unsigned TAP_HI = 9;
  localparam int unsigned TAP_LO = 6;
  localparam logic [STAGES-1:0] SEED = 10'h001;
  typedef logic [STAGES-1:0] prstate_t;
endpackage

// File: rtl/prbit_reseed_ctl.sv
module prbit_reseed_ctl (
  input  logic ret_wr,
  input  logic in_isr,
  input  logic no_reseed,
  output logic reseed
);
  always_comb begin
    reseed = ret_wr & ~in_isr & ~no_reseed;
  end
endmodule

// File: rtl/prbit_lfsr.sv
module prbit_lfsr
  import prbit_pkg::*;
#(
  parameter int unsigned W    = STAGES,
  parameter int unsigned THI  = TAP_HI,
  parameter int unsigned TLO  = TAP_LO,
  parameter logic [W-1:0] INIT = SEED
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q, state_d;
  logic         en;
  logic         fb;

  always_comb begin
    fb = state_q[THI] ^ state_q[TLO];
    en = load | adv;
    if (load) state_d = INIT;
    else      state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= INIT;
    else if (en) state_q <= state_d;
  end

  assign state = state_q;

  // R4 R7: a reseed loads the seed on the next edge
  p_reseed_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state_q == INIT));
  p_reseed_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && adv) |=> (state_q == INIT));
  // R3: the state holds when idle
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(state_q));
  // R2: a step shifts the register
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (state_q[W-1:1] == $past(state_q[W-2:0])));
  // R8: the state never reaches all zeros
  p_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/prbit_gen.sv
module prbit_gen
  import prbit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic ret_wr,
  input  logic in_isr,
  input  logic no_reseed,
  output logic rand_bit
);
  logic     reseed;
  prstate_t st;

  prbit_reseed_ctl u_ctl (
    .ret_wr   (ret_wr),
    .in_isr   (in_isr),
    .no_reseed(no_reseed),
    .reseed   (reseed)
  );

  prbit_lfsr #(
    .W   (STAGES),
    .THI (TAP_HI),
    .TLO (TAP_LO),
    .INIT(SEED)
  ) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (reseed),
    .adv  (step_en),
    .state(st)
  );

  assign rand_bit = st[STAGES-1];

  // R5 R6: a write that is gated off acts as no write at all
  p_gated_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_wr && in_isr && !step_en) |=> $stable(rand_bit));
  p_blocked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_wr && no_reseed && !step_en) |=> $stable(rand_bit));
endmodule

// File: tb/test_prbit_gen.sv
module test_prbit_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0, ret_wr = 1'b0, in_isr = 1'b0, no_reseed = 1'b0;
  logic rand_bit;
  int total = 0, bad = 0;
  int model;

  always #2.5 clk = ~clk;

  prbit_gen i_prbit_gen (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ret_wr(ret_wr),
    .in_isr(in_isr), .no_reseed(no_reseed), .rand_bit(rand_bit)
  );

  function automatic int next_state(int s);
    int b;
    b = ((s >> 9) ^ (s >> 6)) & 1;
    return ((s << 1) & 1023) | b;
  endfunction

  task automatic check(string req, logic exp);
    total++;
    if (rand_bit !== exp) begin
      bad++;
      $display("FAIL %s: rand_bit=%0b expected=%0b", req, rand_bit, exp);
    end
  endtask

  task automatic cyc(logic s, logic w, logic i, logic n, string req);
    step_en = s; ret_wr = w; in_isr = i; no_reseed = n;
    @(posedge clk);
    if (w && !i && !n) model = 1;
    else if (s) model = next_state(model);
    #1;
    check(req, model[9]);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ones;
    int period;
    model = 1;
    #7;
    check("R1", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R2 steps
    for (int k = 0; k < 20; k++) cyc(1, 0, 0, 0, "R2");
    // R3 hold
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, "R3");
    // R4 reseed
    cyc(0, 1, 0, 0, "R4");
    for (int k = 0; k < 12; k++) cyc(1, 0, 0, 0, "R2");
    // R5 write in ISR, both with and without a step
    for (int k = 0; k < 4; k++) cyc(k[0], 1, 1, 0, "R5");
    for (int k = 0; k < 6; k++) cyc(1, 0, 0, 0, "R2");
    // R6 blocked writes
    for (int k = 0; k < 4; k++) cyc(k[0], 1, k[1], 1, "R6");
    // R7 collision
    for (int k = 0; k < 9; k++) cyc(1, 0, 0, 0, "R2");
    cyc(1, 1, 0, 0, "R7");
    total++;
    if (model != 1) begin bad++; $display("FAIL R7: model=%0d expected=1", model); end
    cyc(1, 0, 0, 0, "R7");
    // R8 period and balance, from a fresh seed
    cyc(0, 1, 0, 0, "R8");
    ones = 0; period = 0;
    for (int k = 0; k < 1023; k++) begin
      ones += model[9];
      cyc(1, 0, 0, 0, "R8");
      period++;
      if (model == 1 && k < 1022) begin
        total++; bad++;
        $display("FAIL R8: period=%0d expected=1023", period);
      end
    end
    total++;
    if (model != 1) begin bad++; $display("FAIL R8: end state=%0d expected=1", model); end
    total++;
    if (ones != 512) begin bad++; $display("FAIL R8: ones=%0d expected=512", ones); end
    // the output after one more step must match the step from the seed
    cyc(1, 0, 0, 0, "R8");
    // R1 again, mid-sequence
    for (int k = 0; k < 15; k++) cyc(1, 0, 0, 0, "R2");
    @(negedge clk); rst_n = 1'b0; model = 1;
    #1; check("R1", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 10; k++) cyc(1, 0, 0, 0, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule